// File: doc/BRIEF.md
# Compact-Instruction Branch Flow Unit

This unit resolves control flow for the branch-type instructions of a 16-bit compact instruction set. For each accepted instruction it produces the next program counter, the next link register, the instruction-state bit, a pipeline flush pulse and the cycle cost. The program counter input always reads 4 bytes ahead of the executing instruction, as a prefetching pipeline sees it. Instruction fetch and decode stay outside the unit. A decoder upstream presents an operation code, a condition code, the raw offset field, the flags and the register operands. The results appear on registered outputs one clock later.

The unit handles four kinds of branch. The first is the conditional short branch. The second is the unconditional branch. The third is the long branch with link, which is split into two instructions that pass a partial target through the link register. The fourth is the register-indirect branch that can also change the instruction state. A taken branch always adds the 4-byte refill distance to its target and reports 3 cycles. A sequential result advances by 2 and reports 1 cycle.

Top module: `branch_flow_unit`

## Requirements
- R1: `cond_i` is decoded with the standard ordering 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C&!Z), 9 LS (!C|Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z&N==V), 13 LE (Z|N!=V), 14 always. Code 15 is never taken. `flags_i` is {N,Z,C,V}, with N in bit 3.
- R2: When a conditional branch (op 0) is not taken, the result is `pc_o` = `pc_i`+2, `cycles_o` = 1 and no flush.
- R3: A taken conditional branch sets `pc_o` = `pc_i` + sext(`ofs_i`[7:0])*2 + 4. The unconditional branch (op 1) sets `pc_o` = `pc_i` + sext(`ofs_i`[10:0])*2 + 4. Both report `cycles_o` = 3.
- R4: The long-branch first half (op 2) sets `lr_o` = `pc_i` + (sext(`ofs_i`) << 12) and `pc_o` = `pc_i`+2, with `cycles_o` = 1 and no flush.
- R5: The long-branch second half (op 3) sets `pc_o` = `lr_i` + zext(`ofs_i`)*2 + 4 and `lr_o` = (`pc_i`-2) with bit 0 set, with `cycles_o` = 3.
- R6: The exchange branch (op 4) sets `pc_o` = (`rm_i` with bit 0 cleared) + 4 and `compact_o` = `rm_i`[0]. A value of 0 selects the 32-bit state and 1 keeps the compact state. It reports `cycles_o` = 3.
- R7: `done_o` and `flush_o` are registered. `done_o` pulses for one cycle per accepted operation. `flush_o` pulses for one cycle with it for every taken branch and is low otherwise.
- R8: Ops 0, 1 and 4 leave `lr_o` equal to `lr_i`. Every op except 4 leaves `compact_o` at 1.
- R9: After reset `pc_o` and `lr_o` are 0, `compact_o` is 1, `cycles_o` is 0, and `done_o` and `flush_o` are low.
- R10: Op codes 5 to 7, or `valid_i` low, are ignored. `done_o` and `flush_o` stay low and all other outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation: 0 cond, 1 jump, 2 link high, 3 link low, 4 exchange |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | {N,Z,C,V} |
| ofs_i | input | 11 | Raw offset field |
| pc_i | input | 32 | Current PC (reads ahead by 4) |
| lr_i | input | 32 | Current link register |
| rm_i | input | 32 | Register operand for exchange |
| pc_o | output | 32 | Next PC |
| lr_o | output | 32 | Next link register |
| compact_o | output | 1 | 1 when in compact state |
| flush_o | output | 1 | Pipeline refill request |
| cycles_o | output | 2 | Cycle cost of the operation |
| done_o | output | 1 | Outputs updated by an accepted operation |

## Verification
A wrongly decoded condition shows at the ports on the very next clock. The PC lands 2 bytes ahead instead of at the target, or the reverse, and the flush pulse and the 1-versus-3 cycle cost move with it. A corrupt link value from the first long-branch half does not show in the PC until the second half lands. For that reason the bench checks `lr_o` directly after each half. A flush that lingers or a state bit that sticks is caught on the idle cycle that follows, because the reference model is compared on every clock.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [2:0] {
      OP_COND    = 3'd0,
      OP_JUMP    = 3'd1,
      OP_LINK_HI = 3'd2,
      OP_LINK_LO = 3'd3,
      OP_EXCH    = 3'd4
   } bfu_op_e;

   localparam int CYC_SEQ   = 1;
   localparam int CYC_TAKEN = 3;
endpackage

// File: rtl/bfu_cond_eval.sv
module bfu_cond_eval #(
   parameter bit NV_TAKEN = 1'b0
) (
   input  logic [3:0] cond_i,
   input  logic [3:0] flags_i,
   output logic       pass_o
);
   logic n, z, c, v, nv_pass;
   assign {n, z, c, v} = flags_i;

   generate
      if (NV_TAKEN) begin : g_nv_always
         assign nv_pass = 1'b1;
      end else begin : g_nv_never
         assign nv_pass = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (cond_i)
         4'd0:  pass_o = z;
         4'd1:  pass_o = !z;
         4'd2:  pass_o = c;
         4'd3:  pass_o = !c;
         4'd4:  pass_o = n;
         4'd5:  pass_o = !n;
         4'd6:  pass_o = v;
         4'd7:  pass_o = !v;
         4'd8:  pass_o = c && !z;
         4'd9:  pass_o = !c || z;
         4'd10: pass_o = (n == v);
         4'd11: pass_o = (n != v);
         4'd12: pass_o = !z && (n == v);
         4'd13: pass_o = z || (n != v);
         4'd14: pass_o = 1'b1;
         default: pass_o = nv_pass;
      endcase
   end

   always_comb begin
      if (cond_i == 4'd14) a_r1_always: assert (pass_o);
   end
endmodule

// File: rtl/bfu_target_calc.sv
module bfu_target_calc
   import bfu_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 11,
   parameter int SHORT_W = 8,
   parameter int REFILL  = 4,
   parameter int STEP    = 2,
   parameter int CYC_W   = 2
) (
   input  logic [2:0]        op_i,
   input  logic              cond_ok_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] lr_i,
   input  logic [ADDR_W-1:0] rm_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] lr_o,
   output logic              compact_o,
   output logic              taken_o,
   output logic              legal_o,
   output logic [CYC_W-1:0]  cyc_o
);
   localparam int HI_SHIFT = OFS_W + 1;
   localparam logic [ADDR_W-1:0] REFILL_V = ADDR_W'(REFILL);
   localparam logic [ADDR_W-1:0] STEP_V   = ADDR_W'(STEP);

   bfu_op_e op_e;
   logic [ADDR_W-1:0] short_disp, long_disp, upper_disp, lower_disp, exch_tgt;

   assign op_e       = bfu_op_e'(op_i);
   assign short_disp = {{(ADDR_W-SHORT_W){ofs_i[SHORT_W-1]}}, ofs_i[SHORT_W-1:0]} << 1;
   assign long_disp  = {{(ADDR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i} << 1;
   assign upper_disp = {{(ADDR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i} << HI_SHIFT;
   assign lower_disp = {{(ADDR_W-OFS_W){1'b0}}, ofs_i} << 1;
   assign exch_tgt   = {rm_i[ADDR_W-1:1], 1'b0};

   always_comb begin
      pc_o      = pc_i + STEP_V;
      lr_o      = lr_i;
      compact_o = 1'b1;
      taken_o   = 1'b0;
      legal_o   = 1'b1;
      cyc_o     = CYC_W'(CYC_SEQ);
      case (op_e)
         OP_COND: begin
            if (cond_ok_i) begin
               pc_o    = pc_i + short_disp + REFILL_V;
               taken_o = 1'b1;
               cyc_o   = CYC_W'(CYC_TAKEN);
            end
         end
         OP_JUMP: begin
            pc_o    = pc_i + long_disp + REFILL_V;
            taken_o = 1'b1;
            cyc_o   = CYC_W'(CYC_TAKEN);
         end
         OP_LINK_HI: begin
            lr_o = pc_i + upper_disp;
         end
         OP_LINK_LO: begin
            pc_o    = lr_i + lower_disp + REFILL_V;
            lr_o    = (pc_i - STEP_V) | ADDR_W'(1);
            taken_o = 1'b1;
            cyc_o   = CYC_W'(CYC_TAKEN);
         end
         OP_EXCH: begin
            pc_o      = exch_tgt + REFILL_V;
            compact_o = rm_i[0];
            taken_o   = 1'b1;
            cyc_o     = CYC_W'(CYC_TAKEN);
         end
         default: legal_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/branch_flow_unit.sv
module branch_flow_unit
   import bfu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFS_W    = 11,
   parameter int SHORT_W  = 8,
   parameter int REFILL   = 4,
   parameter int STEP     = 2,
   parameter int CYC_W    = 2,
   parameter bit NV_TAKEN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [2:0]        op_i,
   input  logic [3:0]        cond_i,
   input  logic [3:0]        flags_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] lr_i,
   input  logic [ADDR_W-1:0] rm_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] lr_o,
   output logic              compact_o,
   output logic              flush_o,
   output logic [CYC_W-1:0]  cycles_o,
   output logic              done_o
);
   generate
      if (SHORT_W >= OFS_W) begin : g_bad_short
         $error("SHORT_W must be narrower than OFS_W");
      end
      if (ADDR_W < OFS_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for the offset field");
      end
      if ((1 << CYC_W) <= CYC_TAKEN) begin : g_bad_cyc
         $error("CYC_W cannot hold the taken-branch cost");
      end
   endgenerate

   logic              cond_ok, nxt_compact, nxt_taken, nxt_legal;
   logic [ADDR_W-1:0] nxt_pc, nxt_lr;
   logic [CYC_W-1:0]  nxt_cyc;
   logic              accept;

   bfu_cond_eval #(.NV_TAKEN(NV_TAKEN)) u_cond (
      .cond_i (cond_i),
      .flags_i(flags_i),
      .pass_o (cond_ok)
   );

   bfu_target_calc #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SHORT_W(SHORT_W),
      .REFILL(REFILL), .STEP(STEP), .CYC_W(CYC_W)
   ) u_calc (
      .op_i     (op_i),
      .cond_ok_i(cond_ok),
      .pc_i     (pc_i),
      .lr_i     (lr_i),
      .rm_i     (rm_i),
      .ofs_i    (ofs_i),
      .pc_o     (nxt_pc),
      .lr_o     (nxt_lr),
      .compact_o(nxt_compact),
      .taken_o  (nxt_taken),
      .legal_o  (nxt_legal),
      .cyc_o    (nxt_cyc)
   );

   assign accept = valid_i && nxt_legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o      <= '0;
         lr_o      <= '0;
         compact_o <= 1'b1;
         cycles_o  <= '0;
         done_o    <= 1'b0;
         flush_o   <= 1'b0;
      end else begin
         done_o  <= accept;
         flush_o <= accept && nxt_taken;
         if (accept) begin
            pc_o      <= nxt_pc;
            lr_o      <= nxt_lr;
            compact_o <= nxt_compact;
            cycles_o  <= nxt_cyc;
         end
      end
   end

   a_r7_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(valid_i));
   a_r7_flush_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> done_o);
   a_r3_taken_cost: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> cycles_o == CYC_W'(CYC_TAKEN));
   a_r2_seq_cost: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !flush_o) |-> cycles_o == CYC_W'(CYC_SEQ));
   a_r8_lr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ($past(op_i) == 3'd0 || $past(op_i) == 3'd1 || $past(op_i) == 3'd4))
      |-> lr_o == $past(lr_i));
   a_r6_state_drop_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(compact_o) |-> flush_o);
   a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(op_i) <= 3'd4);
endmodule

// File: tb/branch_flow_unit_tb.sv
module branch_flow_unit_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [3:0]  cond_i = '0;
   logic [3:0]  flags_i = '0;
   logic [10:0] ofs_i = '0;
   logic [31:0] pc_i = '0, lr_i = '0, rm_i = '0;
   logic [31:0] pc_o, lr_o;
   logic        compact_o, flush_o, done_o;
   logic [1:0]  cycles_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [31:0] e_pc = '0, e_lr = '0;
   logic        e_compact = 1'b1, e_flush = 1'b0, e_done = 1'b0;
   logic [1:0]  e_cyc = '0;
   string       e_req = "R9";

   always #(PERIOD/2) clk = ~clk;

   branch_flow_unit u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .cond_i(cond_i),
      .flags_i(flags_i), .ofs_i(ofs_i), .pc_i(pc_i), .lr_i(lr_i), .rm_i(rm_i),
      .pc_o(pc_o), .lr_o(lr_o), .compact_o(compact_o), .flush_o(flush_o),
      .cycles_o(cycles_o), .done_o(done_o)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(e_req, "pc", pc_o, e_pc);
      chk(e_req, "lr", lr_o, e_lr);
      chk(e_req, "compact", {31'd0, compact_o}, {31'd0, e_compact});
      chk("R7", "flush", {31'd0, flush_o}, {31'd0, e_flush});
      chk("R7", "done", {31'd0, done_o}, {31'd0, e_done});
      chk(e_req, "cycles", {30'd0, cycles_o}, {30'd0, e_cyc});
   endtask

   function automatic bit cond_pass(logic [3:0] cc, logic [3:0] f);
      bit n, z, c, v;
      {n, z, c, v} = f;
      case (cc)
         0: return z;           1: return !z;
         2: return c;           3: return !c;
         4: return n;           5: return !n;
         6: return v;           7: return !v;
         8: return c & !z;      9: return !c | z;
         10: return n == v;     11: return n != v;
         12: return !z & (n == v);
         13: return z | (n != v);
         14: return 1;
         default: return 0;
      endcase
   endfunction

   // Reference model for one clock; valid=0 means idle.
   task automatic step(bit vld, int op, int cc, int fl, int ofs, logic [31:0] pc,
                       logic [31:0] lr, logic [31:0] rm);
      int sofs;
      @(negedge clk);
      valid_i = vld; op_i = 3'(op); cond_i = 4'(cc); flags_i = 4'(fl);
      ofs_i = 11'(ofs); pc_i = pc; lr_i = lr; rm_i = rm;
      e_done = 1'b0; e_flush = 1'b0;
      if (vld && op <= 4) begin
         e_done = 1'b1; e_compact = 1'b1; e_lr = lr; e_cyc = 2'd1; e_pc = pc + 2;
         case (op)
            0: begin
               e_req = "R1";
               if (cond_pass(4'(cc), 4'(fl))) begin
                  sofs = int'($signed(8'(ofs)));
                  e_pc = pc + 32'(sofs * 2) + 4; e_flush = 1'b1; e_cyc = 2'd3;
               end else e_req = "R2";
            end
            1: begin
               e_req = "R3";
               sofs = int'($signed(11'(ofs)));
               e_pc = pc + 32'(sofs * 2) + 4; e_flush = 1'b1; e_cyc = 2'd3;
            end
            2: begin
               e_req = "R4";
               sofs = int'($signed(11'(ofs)));
               e_lr = pc + 32'(sofs * 4096);
            end
            3: begin
               e_req = "R5";
               e_pc = lr + 32'((ofs & 2047) * 2) + 4;
               e_lr = (pc - 2) | 32'd1; e_flush = 1'b1; e_cyc = 2'd3;
            end
            default: begin
               e_req = "R6";
               e_pc = (rm & ~32'd1) + 4; e_compact = rm[0];
               e_flush = 1'b1; e_cyc = 2'd3;
            end
         endcase
         if (op == 0 || op == 1 || op == 4) e_req = {e_req, "/R8"};
      end else begin
         e_req = "R10";
      end
      @(posedge clk);
      #1;
      compare_all();
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      e_req = "R9";
      compare_all();
      @(negedge clk);
      rst_n = 1'b1;

      // R3: taken branch -192 bytes, R2: not taken advances by 2
      step(1, 0, 0, 4'b0000, 11'h0A0, 32'd4589344, 32'd7, 32'd0);
      chk("R2", "not-taken pc", pc_o, 32'd4589346);
      step(1, 0, 0, 4'b0100, 11'h0A0, 32'd4589344, 32'd7, 32'd0);
      chk("R3", "taken pc", pc_o, 32'd4589156);
      step(0, 0, 0, 0, 0, 32'd0, 32'd0, 32'd0); // R7 flush drops

      // R1: every condition code across flag patterns
      for (int cc = 0; cc < 16; cc++)
         for (int fl = 0; fl < 16; fl += 3)
            step(1, 0, cc, fl, 11'h07F, 32'h1000 + 32'(cc * 64), 32'd0, 32'd0);

      // R3: unconditional -920
      step(1, 1, 0, 0, 2048 - 460, 32'd4589344, 32'd5, 32'd0);
      chk("R3", "jump pc", pc_o, 32'd4588428);
      step(1, 1, 0, 0, 11'h3FF, 32'h2000, 32'd5, 32'd0);

      // R4 / R5: long branch with link
      step(1, 2, 0, 0, 11'b10010111110, 32'd4589344, 32'd0, 32'd0);
      chk("R4", "link-high lr", lr_o, 32'd1173280);
      step(1, 3, 0, 0, 11'b10010111110, 32'd4589344, 32'd1173280, 32'd0);
      chk("R5", "link-low pc", pc_o, 32'd1175712);
      chk("R5", "link-low lr", lr_o, 32'd4589343);
      step(1, 2, 0, 0, 11'h001, 32'h100, 32'd0, 32'd0);

      // R6: exchange
      step(1, 4, 0, 0, 0, 32'h40, 32'h99, 32'd2189988);
      chk("R6", "exch wide state", {31'd0, compact_o}, 32'd0);
      step(1, 4, 0, 0, 0, 32'h40, 32'h99, 32'd2189989);
      chk("R6", "exch compact pc", pc_o, 32'd2189992);
      step(1, 4, 0, 0, 0, 32'h40, 32'h99, 32'd2189988);
      step(1, 0, 14, 0, 11'h004, 32'h800, 32'h99, 32'd0); // R8 state back to 1

      // R10: illegal ops and idle hold everything
      for (int op = 5; op < 8; op++)
         step(1, op, 14, 0, 11'h010, 32'hDEAD0, 32'hBEEF0, 32'h12345);
      step(0, 1, 0, 0, 11'h010, 32'hDEAD0, 32'hBEEF0, 32'h12345);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule